// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder Model

This block is a synthesizable, device-side model of an asynchronous DRAM with a 16-bit data bus split into two byte lanes. It oversamples the row strobe, the two byte column strobes, the write enable, the output enable and a 9-bit multiplexed address on a fast system clock. From the order in which these pins change it works out the kind of each memory cycle. It keeps a small row-by-column backing array, drives read data on the enabled lanes and takes write data from them. An internal row counter serves refresh cycles that the controller starts with the column strobe already low.

Controller testbenches use it in place of a real DRAM and as a protocol monitor. The cycle kind, the latched row and a protocol-error pulse are brought out so that a bench can see how the model understood each cycle. All strobe pins are active low and must be synchronous to the model clock. A pin change becomes an edge at the next rising clock edge, and the registered outputs change right after that edge.

Top module: `dram_strobe_model`

## Requirements
- R1: The merged column strobe is active while either byte strobe is low. An access starts when the first strobe falls and ends when the last one rises. A second lane that falls while the other is still low joins the access under way.
- R2: A row strobe fall while the merged column strobe is already low is a refresh. The latched row is taken from an internal counter, which starts at 0 after reset and advances by one for each such refresh. The address pins are ignored, and no output lane is newly enabled.
- R3: When write enable is low at the merged column strobe fall, the cycle is an early write. The data of the active lanes is stored and no lane is driven.
- R4: When write enable falls after the column strobe fall of a read, and output enable has stayed high since that fall, the cycle becomes a late write and the active lanes are stored.
- R5: When the same write enable fall comes after output enable has been low since the column strobe fall, the cycle is a read-modify-write. The active lanes are stored and the outputs turn off.
- R6: Once the row strobe and both column strobes have been high at a clock edge, no lane is driven and the cycle kind returns to idle.
- R7: Read data stays driven after the column strobe rises, and also across a row strobe rise with the column strobe low. It is replaced only at the next column strobe fall.
- R8: Output enable high turns every lane off while it is high, and the lanes come back when it returns low. Write enable low with a column strobe low turns the lanes off until the next read.
- R9: A lane whose strobe is high during a write is not written. A lane whose strobe stayed high through a read is not driven. Lane 0 is dq[7:0] under the lower strobe, and lane 1 is dq[15:8] under the upper strobe.
- R10: A row strobe fall with the column strobe high latches the address as the row. Each later column strobe fall in the same row cycle latches a new column, so page-mode reads and writes reach any column of that row.
- R11: When a column strobe falls while the row strobe is high, and then rises without a row strobe fall in between, proto_err pulses high for one cycle.
- R12: cyc_kind codes are 0 idle, 1 row open without access, 2 read, 3 early write, 4 late write, 5 read-modify-write, 6 refresh. While reset is asserted, dq_oe, cyc_kind, row_latched and proto_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Column strobe for the upper byte lane, active low |
| lcas_n | input | 1 | Column strobe for the lower byte lane, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| dq_in | input | 16 | Data from the controller |
| dq_out | output | 16 | Read data toward the controller |
| dq_oe | output | 2 | Per-lane output drive enable |
| cyc_kind | output | 3 | Decoded kind of the current cycle |
| row_latched | output | 9 | Row of the current cycle |
| proto_err | output | 1 | One-cycle pulse on a column strobe pulse with no row strobe fall |

## Verification
A wrong cycle kind shows on cyc_kind in the cycle after the edge that caused it. It also changes what a later read of the same column returns, because a write lands on the wrong lanes or does not happen at all. A lane-valid bit that was cleared or kept in error shows on dq_oe at the very next sampling point, so the EDO hold and the disable cases are checked one step at a time. A refresh counter that is off by one shows on row_latched at the next refresh, and a stale hold shows as wrong data on a hidden refresh.

// File: rtl/dram_strobe_pkg.sv
package dram_strobe_pkg;
  typedef enum logic [2:0] {
    CK_IDLE    = 3'd0,
    CK_ROWONLY = 3'd1,
    CK_READ    = 3'd2,
    CK_EWRITE  = 3'd3,
    CK_LWRITE  = 3'd4,
    CK_RMW     = 3'd5,
    CK_CBR     = 3'd6
  } cyc_kind_e;
endpackage

// File: rtl/dram_rst_sync.sv
module dram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) pipe_q <= '0;
    else           pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = pipe_q[STAGES-1];
endmodule

// File: rtl/dram_lane_store.sv
module dram_lane_store #(
  parameter int LANES    = 2,
  parameter int LANE_W   = 8,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  localparam int IDX_W   = ROW_BITS + COL_BITS,
  localparam int DEPTH   = 1 << IDX_W,
  localparam int DATA_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LANES-1:0]  wr_lane,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  // one independent array per byte lane, so a byte write needs no read-merge
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lane[l]) cells[wr_idx] <= wr_data[l*LANE_W +: LANE_W];
    end

    assign rd_data[l*LANE_W +: LANE_W] = cells[rd_idx];
  end
endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dram_strobe_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int LANES    = 2,
  parameter int COL_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_act,
  input  logic                we_act,
  input  logic                oe_act,
  input  logic [LANES-1:0]    lane_act,
  input  logic [ADDR_W-1:0]   addr,
  output cyc_kind_e           kind_q,
  output logic [ADDR_W-1:0]   row_q,
  output logic [COL_BITS-1:0] col_idx,
  output logic [LANES-1:0]    wr_lane,
  output logic                load_rd,
  output logic [LANES-1:0]    valid_q,
  output logic                proto_err_q
);
  // sampled pin levels from the previous edge
  logic             ras_q, we_q;
  logic [LANES-1:0] lane_q;

  logic [COL_BITS-1:0] col_q;
  logic [ADDR_W-1:0]   rfc_q;
  logic                oe_seen_q, cas_pre_q;

  // edges and merged strobe
  logic             cas_act, cas_was, cas_on, cas_off, ras_on, we_on;
  logic [LANES-1:0] lane_on;
  logic             all_idle, access_ok;
  logic             rd_start, ew_start, ew_lane, lw_start, rmw_sel;

  // next-state values and enables
  cyc_kind_e           kind_d;
  logic [ADDR_W-1:0]   row_d, rfc_d;
  logic                row_en, rfc_en, col_en;
  logic [LANES-1:0]    valid_d;
  logic                oe_seen_d, cas_pre_d, proto_d;

  always_comb begin
    cas_act   = |lane_act;
    cas_was   = |lane_q;
    cas_on    = cas_act & ~cas_was;
    cas_off   = ~cas_act & cas_was;
    ras_on    = ras_act & ~ras_q;
    we_on     = we_act & ~we_q;
    lane_on   = lane_act & ~lane_q;
    all_idle  = ~ras_act & ~cas_act;
    access_ok = ras_act & ~ras_on & (kind_q != CK_CBR);

    rd_start  = access_ok & cas_on & ~we_act;
    ew_start  = access_ok & cas_on & we_act;
    ew_lane   = (kind_q == CK_EWRITE) & access_ok & ~cas_on & we_act & (|lane_on);
    lw_start  = (kind_q == CK_READ) & ras_act & cas_act & ~cas_on & we_on;
    rmw_sel   = oe_seen_q | oe_act;

    col_en    = access_ok & cas_on;
    col_idx   = col_en ? addr[COL_BITS-1:0] : col_q;
    load_rd   = rd_start;

    if (ew_start | lw_start) wr_lane = lane_act;
    else if (ew_lane)        wr_lane = lane_on;
    else                     wr_lane = '0;
  end

  // cycle kind, row latch and refresh counter
  always_comb begin
    kind_d = kind_q;
    row_d  = row_q;
    row_en = 1'b0;
    rfc_d  = rfc_q;
    rfc_en = 1'b0;
    if (all_idle) begin
      kind_d = CK_IDLE;
    end else if (ras_on) begin
      row_en = 1'b1;
      if (cas_was) begin
        kind_d = CK_CBR;
        row_d  = rfc_q;
        rfc_d  = rfc_q + 1'b1;
        rfc_en = 1'b1;
      end else begin
        kind_d = CK_ROWONLY;
        row_d  = addr;
      end
    end else if (rd_start) begin
      kind_d = CK_READ;
    end else if (ew_start) begin
      kind_d = CK_EWRITE;
    end else if (lw_start) begin
      kind_d = rmw_sel ? CK_RMW : CK_LWRITE;
    end
  end

  // output lane validity (EDO hold), read-modify-write tracking, protocol check
  always_comb begin
    if (rd_start)                valid_d = lane_act;
    else if (ew_start)           valid_d = '0;
    else if (all_idle)           valid_d = '0;
    else if (we_act & cas_act)   valid_d = '0;
    else if ((kind_q == CK_READ) & (|valid_q))
                                 valid_d = valid_q | lane_on;
    else                         valid_d = valid_q;

    if (rd_start)                                   oe_seen_d = oe_act;
    else if (all_idle)                              oe_seen_d = 1'b0;
    else if ((kind_q == CK_READ) & cas_act & oe_act) oe_seen_d = 1'b1;
    else                                            oe_seen_d = oe_seen_q;

    if (ras_on)                    cas_pre_d = 1'b0;
    else if (cas_on & ~ras_act)    cas_pre_d = 1'b1;
    else if (cas_off)              cas_pre_d = 1'b0;
    else                           cas_pre_d = cas_pre_q;

    proto_d = cas_off & ~ras_act & cas_pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q       <= 1'b0;
      we_q        <= 1'b0;
      lane_q      <= '0;
      kind_q      <= CK_IDLE;
      row_q       <= '0;
      col_q       <= '0;
      rfc_q       <= '0;
      valid_q     <= '0;
      oe_seen_q   <= 1'b0;
      cas_pre_q   <= 1'b0;
      proto_err_q <= 1'b0;
    end else begin
      ras_q       <= ras_act;
      we_q        <= we_act;
      lane_q      <= lane_act;
      kind_q      <= kind_d;
      if (row_en) row_q <= row_d;
      if (col_en) col_q <= addr[COL_BITS-1:0];
      if (rfc_en) rfc_q <= rfc_d;
      valid_q     <= valid_d;
      oe_seen_q   <= oe_seen_d;
      cas_pre_q   <= cas_pre_d;
      proto_err_q <= proto_d;
    end
  end
endmodule

// File: rtl/dram_strobe_model.sv
module dram_strobe_model
  import dram_strobe_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int LANE_W   = 8,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  localparam int LANES   = 2,
  localparam int DATA_W  = LANES * LANE_W,
  localparam int IDX_W   = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              ucas_n,
  input  logic              lcas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [LANES-1:0]  dq_oe,
  output logic [2:0]        cyc_kind,
  output logic [ADDR_W-1:0] row_latched,
  output logic              proto_err
);
  logic                rst_int;
  cyc_kind_e           kind;
  logic [ADDR_W-1:0]   row;
  logic [COL_BITS-1:0] col_idx;
  logic [LANES-1:0]    wr_lane, valid;
  logic                load_rd, perr;
  logic [DATA_W-1:0]   rd_data, dout_q;
  logic [IDX_W-1:0]    wr_idx, rd_idx;

  dram_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int)
  );

  dram_strobe_seq #(
    .ADDR_W   (ADDR_W),
    .LANES    (LANES),
    .COL_BITS (COL_BITS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int),
    .ras_act     (~ras_n),
    .we_act      (~we_n),
    .oe_act      (~oe_n),
    .lane_act    ({~ucas_n, ~lcas_n}),
    .addr        (addr),
    .kind_q      (kind),
    .row_q       (row),
    .col_idx     (col_idx),
    .wr_lane     (wr_lane),
    .load_rd     (load_rd),
    .valid_q     (valid),
    .proto_err_q (perr)
  );

  assign wr_idx = {row[ROW_BITS-1:0], col_idx};
  assign rd_idx = {row[ROW_BITS-1:0], addr[COL_BITS-1:0]};

  dram_lane_store #(
    .LANES    (LANES),
    .LANE_W   (LANE_W),
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS)
  ) u_store (
    .clk     (clk),
    .wr_idx  (wr_idx),
    .wr_lane (wr_lane),
    .wr_data (dq_in),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)     dout_q <= '0;
    else if (load_rd) dout_q <= rd_data;
  end

  assign dq_out      = dout_q;
  assign dq_oe       = valid & {LANES{~oe_n}};
  assign cyc_kind    = kind;
  assign row_latched = row;
  assign proto_err   = perr;
endmodule

// File: rtl/dram_strobe_chk.sv
module dram_strobe_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              ucas_n,
  input logic              lcas_n,
  input logic              we_n,
  input logic [1:0]        dq_oe,
  input logic [2:0]        cyc_kind,
  input logic [ADDR_W-1:0] row_latched,
  input logic              proto_err
);
  // R3
  early_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd3) |-> (dq_oe == 2'b00));

  // R6
  idle_highz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_n & ucas_n & lcas_n) |-> (dq_oe == 2'b00));

  // R8
  we_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!we_n & !(ucas_n & lcas_n)) |-> (dq_oe == 2'b00));

  // R11
  proto_ras_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(ras_n));

  // R10
  row_only_at_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_latched) |-> !$past(ras_n));
endmodule

bind dram_strobe_model dram_strobe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int),
  .ras_n       (ras_n),
  .ucas_n      (ucas_n),
  .lcas_n      (lcas_n),
  .we_n        (we_n),
  .dq_oe       (dq_oe),
  .cyc_kind    (cyc_kind),
  .row_latched (row_latched),
  .proto_err   (proto_err)
);

// File: tb/tb_dram_strobe_model.sv
module tb_dram_strobe_model;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ras_n, ucas_n, lcas_n, we_n, oe_n;
  logic [8:0]  addr;
  logic [15:0] dq_in;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic [2:0]  cyc_kind;
  logic [8:0]  row_latched;
  logic        proto_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dram_strobe_model dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .cyc_kind(cyc_kind), .row_latched(row_latched), .proto_err(proto_err)
  );

  // vector: pins{ras,ucas,lcas,we,oe} | addr | din | exp_oe | exp_dout | exp_kind
  localparam int NV = 28;
  localparam logic [50:0] VEC [NV] = '{
    {5'b11111, 9'd0, 16'h0000, 2'b00, 16'h0000, 3'd0},
    {5'b01111, 9'd5, 16'h0000, 2'b00, 16'h0000, 3'd1},
    {5'b00001, 9'd2, 16'hA1B2, 2'b00, 16'h0000, 3'd3},
    {5'b01111, 9'd2, 16'h0000, 2'b00, 16'h0000, 3'd3},
    {5'b11111, 9'd0, 16'h0000, 2'b00, 16'h0000, 3'd0},
    {5'b01111, 9'd5, 16'h0000, 2'b00, 16'h0000, 3'd1},
    {5'b00010, 9'd2, 16'h0000, 2'b11, 16'hA1B2, 3'd2},
    {5'b01110, 9'd2, 16'h0000, 2'b11, 16'hA1B2, 3'd2},
    {5'b01111, 9'd2, 16'h0000, 2'b00, 16'h0000, 3'd2},
    {5'b01110, 9'd2, 16'h0000, 2'b11, 16'hA1B2, 3'd2},
    {5'b00001, 9'd3, 16'h1234, 2'b00, 16'h0000, 3'd3},
    {5'b01111, 9'd3, 16'h0000, 2'b00, 16'h0000, 3'd3},
    {5'b01001, 9'd3, 16'h77C3, 2'b00, 16'h0000, 3'd3},
    {5'b01111, 9'd3, 16'h0000, 2'b00, 16'h0000, 3'd3},
    {5'b00110, 9'd3, 16'h0000, 2'b10, 16'h12C3, 3'd2},
    {5'b00010, 9'd3, 16'h0000, 2'b11, 16'h12C3, 3'd2},
    {5'b01110, 9'd3, 16'h0000, 2'b11, 16'h12C3, 3'd2},
    {5'b00011, 9'd2, 16'h0000, 2'b00, 16'h0000, 3'd2},
    {5'b00001, 9'd2, 16'h0F0F, 2'b00, 16'h0000, 3'd4},
    {5'b01111, 9'd2, 16'h0000, 2'b00, 16'h0000, 3'd4},
    {5'b00010, 9'd2, 16'h0000, 2'b11, 16'h0F0F, 3'd2},
    {5'b00001, 9'd2, 16'h5A5A, 2'b00, 16'h0000, 3'd5},
    {5'b01110, 9'd2, 16'h0000, 2'b00, 16'h0000, 3'd5},
    {5'b00010, 9'd2, 16'h0000, 2'b11, 16'h5A5A, 3'd2},
    {5'b01110, 9'd2, 16'h0000, 2'b11, 16'h5A5A, 3'd2},
    {5'b11111, 9'd0, 16'h0000, 2'b00, 16'h0000, 3'd0},
    {5'b01111, 9'd6, 16'h0000, 2'b00, 16'h0000, 3'd1},
    {5'b11111, 9'd0, 16'h0000, 2'b00, 16'h0000, 3'd0}
  };

  localparam string VTAG [NV] = '{
    "R6 idle", "R10 row open", "R3 early write", "R3 hold", "R6 close",
    "R10 row open", "R10 read", "R7 edo hold", "R8 oe high", "R8 oe low again",
    "R3 page write", "R3 hold", "R9 lower-only write", "R3 hold",
    "R9 upper-only read", "R1 lane joins", "R7 edo hold", "R4 read oe high",
    "R4 late write", "R4 hold", "R4 readback", "R5 rmw", "R5 outputs off",
    "R5 readback", "R7 edo hold", "R6 close", "R10 row only", "R6 close"
  };

  task automatic drive(input logic [4:0] p, input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    {ras_n, ucas_n, lcas_n, we_n, oe_n} = p;
    addr  = a;
    dq_in = d;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    {ras_n, ucas_n, lcas_n, we_n, oe_n} = 5'b11111;
    addr = '0;
    dq_in = '0;
    repeat (3) @(posedge clk);
    #2;
    // R12 reset state
    check("R12 reset dq_oe", dq_oe, 0);
    check("R12 reset kind", cyc_kind, 0);
    check("R12 reset row", row_latched, 0);
    check("R12 reset proto", proto_err, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      logic [15:0] m;
      v = VEC[i];
      drive(v[50:46], v[45:37], v[36:21]);
      m = {{8{v[20]}}, {8{v[19]}}};
      check({VTAG[i], " dq_oe"}, dq_oe, v[20:19]);
      check({VTAG[i], " kind"}, cyc_kind, v[2:0]);
      if (|v[20:19]) check({VTAG[i], " data"}, dq_out & m, v[18:3] & m);
    end
    check("R10 row-only latch", row_latched, 6);

    // R2 refresh with strobe low before row fall, address ignored
    drive(5'b10011, 9'h1FF, 16'h0);
    drive(5'b00011, 9'h1FF, 16'h0);
    check("R2 cbr kind", cyc_kind, 6);
    check("R2 cbr row", row_latched, 0);
    check("R2 cbr quiet", dq_oe, 0);
    drive(5'b11111, 9'h0, 16'h0);
    check("R11 no error after cbr", proto_err, 0);
    drive(5'b10011, 9'h1FF, 16'h0);
    drive(5'b00011, 9'h1FF, 16'h0);
    check("R2 cbr counter advance", row_latched, 1);
    drive(5'b11111, 9'h0, 16'h0);

    // R11 column pulse without row fall
    drive(5'b10111, 9'h0, 16'h0);
    check("R11 no error yet", proto_err, 0);
    drive(5'b11111, 9'h0, 16'h0);
    check("R11 error pulse", proto_err, 1);
    drive(5'b11111, 9'h0, 16'h0);
    check("R11 pulse ends", proto_err, 0);

    // R7 hold across row rise, then hidden refresh (R2)
    drive(5'b01111, 9'd5, 16'h0);
    drive(5'b00010, 9'd2, 16'h0);
    check("R10 read col2", dq_out, 16'h5A5A);
    drive(5'b10010, 9'd2, 16'h0);
    check("R7 hold row high", dq_oe, 2'b11);
    drive(5'b00010, 9'd7, 16'h0);
    check("R2 hidden kind", cyc_kind, 6);
    check("R2 hidden row", row_latched, 2);
    check("R7 hidden data oe", dq_oe, 2'b11);
    check("R7 hidden data", dq_out, 16'h5A5A);
    drive(5'b11111, 9'h0, 16'h0);
    check("R6 after hidden", dq_oe, 0);

    // R8 write enable low with column strobe low turns lanes off
    drive(5'b01111, 9'd5, 16'h0);
    drive(5'b00010, 9'd3, 16'h0);
    check("R9 byte merge readback", dq_out, 16'h12C3);
    drive(5'b00000, 9'd3, 16'h12C3);
    check("R8 we disable", dq_oe, 0);
    check("R5 rmw kind", cyc_kind, 5);
    drive(5'b11111, 9'h0, 16'h0);

    // R12 reset in the middle of a read
    drive(5'b01111, 9'd5, 16'h0);
    drive(5'b00010, 9'd2, 16'h0);
    check("R10 read before reset", dq_oe, 2'b11);
    @(negedge clk) rst_n = 1'b0;
    #2;
    check("R12 async reset oe", dq_oe, 0);
    check("R12 async reset kind", cyc_kind, 0);

    finish_run();
  end
endmodule